// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Converters

This block adds two 16-bit unsigned operands and a carry-in in purely combinational logic, producing a 16-bit sum and a carry-out. The operand bits are divided into five segments whose widths grow toward the most significant end: 2, 2, 3, 4 and 5 bits, starting from the least significant bit. The lowest segment is a plain ripple adder fed by the external carry-in.

Each of the four upper segments computes its result once, assuming an incoming carry of zero. It then forms the carry-in-one result by adding one to that value, segment carry included, with a small increment network. The increment network takes the place of a second ripple adder. A 2-to-1 selector, driven by the true carry arriving from the segment below, picks both the segment's sum bits and its outgoing carry. The selected carry of the top segment is the block's carry-out.

The block is meant for datapaths that need a fast adder with less area than a classic carry-select design. It has no clock and no state. Its outputs follow its inputs after the combinational delay.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals a + b + cin, taken as a 17-bit unsigned value.
- R2: Segment boundaries lie after bits 1, 3, 6 and 10. A carry produced at the top bit of one segment enters the lowest bit of the next segment. For example, a = 0x0002 and b = 0x0002 gives 0x0004.
- R3: Sum bits 1:0 depend only on a[1:0], b[1:0] and cin. They equal the low two bits of a[1:0] + b[1:0] + cin.
- R4: A carry-in of 1 ripples through every segment. With a = 0xFFFF, b = 0x0000 and cin = 1, the result is sum = 0x0000 and cout = 1.
- R5: Each upper segment's sum bits equal its own operand bits plus the true incoming carry. Both choices, carry 0 and carry 1, are selected correctly in every segment.
- R6: cout is the selected outgoing carry of the top segment (bits 15:11). With a = 0xFFFF, b = 0xFFFF and cin = 1, the result is sum = 0xFFFF and cout = 1.
- R7: The block is combinational. Outputs reflect new inputs within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The block holds no state. Any wrong internal value shows at the ports in the same cycle the inputs are applied. A faulty increment network or selector corrupts only the sum bits of one segment, and only when the real carry into that segment is 1. A faulty segment carry corrupts every segment above it. For this reason the stimulus forces carries across each of the four segment boundaries in both directions, and it also includes full-width propagate patterns. Random operands then cover the remaining mix of generate and propagate patterns.

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int G0 = 2,
  parameter int G1 = 2,
  parameter int G2 = 3,
  parameter int G3 = 4,
  parameter int G4 = 5,
  localparam int NG = 5,
  localparam int W = G0 + G1 + G2 + G3 + G4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic int gw(input int g);
    case (g)
      0: return G0;
      1: return G1;
      2: return G2;
      3: return G3;
      default: return G4;
    endcase
  endfunction

  function automatic int goff(input int g);
    int o;
    o = 0;
    for (int i = 0; i < g; i++) o += gw(i);
    return o;
  endfunction

  logic [NG:0] gc;

  for (genvar g = 0; g < NG; g++) begin : grp
    localparam int K = gw(g);
    localparam int O = goff(g);
    logic         cgi;
    logic         co;
    logic [K-1:0] r0;
    logic [K:0]   pre;
    logic [K:0]   inc;
    logic         cr;
    logic         run;

    if (g == 0) begin : g_in
      assign cgi = cin;
    end else begin : g_in
      assign cgi = grp[g-1].co;
    end

    always_comb begin
      cr = (g == 0) ? cgi : 1'b0;
      for (int i = 0; i < K; i++) begin
        r0[i] = a[O+i] ^ b[O+i] ^ cr;
        cr    = (a[O+i] & b[O+i]) | (cr & (a[O+i] ^ b[O+i]));
      end
      pre = {cr, r0};
      run = 1'b1;
      for (int j = 0; j <= K; j++) begin
        inc[j] = pre[j] ^ run;
        run    = run & pre[j];
      end
    end

    if (g == 0) begin : g_sel
      assign {co, sum[O +: K]} = pre;
    end else begin : g_sel
      assign {co, sum[O +: K]} = cgi ? inc : pre;
    end

    assign gc[g] = cgi;
  end

  assign gc[NG] = grp[NG-1].co;
  assign cout   = gc[NG];

endmodule

module sqrt_csel_adder_chk #(
  parameter int G0 = 2,
  parameter int G1 = 2,
  parameter int G2 = 3,
  parameter int G3 = 4,
  parameter int G4 = 5,
  parameter int NG = 5,
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic [NG:0]  gc
);

  function automatic int gw(input int g);
    case (g)
      0: return G0;
      1: return G1;
      2: return G2;
      3: return G3;
      default: return G4;
    endcase
  endfunction

  always_comb begin
    longint tot;
    longint sa, sb, ss, m, t;
    int off;
    tot = longint'(a) + longint'(b) + longint'(cin);
    a_r1_total: assert ({cout, sum} == tot[W:0])
      else $error("R1 total mismatch");
    a_r6_cout: assert (cout == gc[NG])
      else $error("R6 cout not top segment carry");
    a_r3_low: assert (gc[0] == cin)
      else $error("R3 first segment carry-in not cin");
    off = 0;
    for (int g = 0; g < NG; g++) begin
      m  = (longint'(1) << gw(g)) - 1;
      sa = (longint'(a) >> off) & m;
      sb = (longint'(b) >> off) & m;
      ss = (longint'(sum) >> off) & m;
      t  = sa + sb + longint'(gc[g]);
      a_r5_segment: assert (ss == (t & m))
        else $error("R5 segment %0d sum mismatch", g);
      a_r2_carry: assert (gc[g+1] == t[gw(g)])
        else $error("R2 carry out of segment %0d mismatch", g);
      off += gw(g);
    end
  end

endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(
  .G0(G0), .G1(G1), .G2(G2), .G3(G3), .G4(G4), .NG(NG), .W(W)
) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .gc(gc)
);

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  sqrt_csel_adder u_sqrt_csel_adder (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  always #2.5 clk = ~clk;

  task automatic apply(input logic [15:0] va, input logic [15:0] vb,
                       input logic vc, input string tag);
    int exp_i;
    int got_i;
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
    exp_i = int'(va) + int'(vb) + int'(vc);
    got_i = int'({cout, sum});
    n_cmp++;
    if (got_i != exp_i) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%0d got=%h expected=%h",
               tag, va, vb, vc, got_i, exp_i);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lo_q[$];
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: zero inputs, R7 combinational result
    @(negedge clk);
    n_cmp++;
    if ({cout, sum} != 17'd0) begin
      n_bad++;
      $display("FAIL R7: got=%h expected=0", {cout, sum});
    end
    apply(16'h0000, 16'h0000, 1'b1, "R3");
    apply(16'h0003, 16'h0000, 1'b1, "R3");
    apply(16'h0001, 16'h0002, 1'b0, "R3");
    apply(16'hFFFF, 16'h0000, 1'b1, "R4");
    apply(16'h0000, 16'hFFFF, 1'b1, "R4");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R6");
    apply(16'h8000, 16'h8000, 1'b0, "R6");
    apply(16'h0002, 16'h0002, 1'b0, "R2");
    apply(16'h0008, 16'h0008, 1'b0, "R2");
    apply(16'h0040, 16'h0040, 1'b0, "R2");
    apply(16'h0400, 16'h0400, 1'b0, "R2");
    apply(16'h0003, 16'h0001, 1'b0, "R2");
    apply(16'h000F, 16'h0001, 1'b0, "R2");
    apply(16'h007F, 16'h0001, 1'b0, "R2");
    apply(16'h07FF, 16'h0001, 1'b0, "R2");
    lo_q = '{0, 2, 4, 7, 11};
    foreach (lo_q[i]) begin
      apply(16'hAAAA, 16'h5555, 1'b1, "R5");
      apply(16'(1 << lo_q[i]) - 16'd1, 16'd0, 1'b1, "R5");
      apply(16'hFFFF << lo_q[i], 16'(1 << lo_q[i]), 1'b0, "R5");
    end
    apply(16'h5555, 16'h5555, 1'b0, "R1");
    apply(16'h1234, 16'hEDCB, 1'b1, "R1");
    for (int k = 0; k < 4000; k++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule